// File: doc/BRIEF.md
# Debug Memory Access Command Parser

This block sits behind a single-wire debug receiver. It takes the frames that the receiver has already accepted and acknowledged, and rebuilds the memory-access transactions that they carry. A transaction opens with a short command payload. A read or write command is followed by a transfer count and a 24-bit address, sent as three bytes with the most significant byte first. After the address come the data bytes. The parser reports the command, presents the assembled address, and then hands each data byte onward with its direction and its own running address.

The receiver needs to know how long the next payload will be, so the parser drives a framing-mode output. A 1 on this output asks for a short command payload and a 0 asks for a full byte. A synchronisation event seen by the receiver returns the parser to the command stage at once. The parser does not check parity and does not perform any memory access.

Top module: `dbg_access_parser`

## Requirements
- R1: After reset `shortFrame` is 1 and `cmdValid`, `cmdUnknown`, `addrValid` and `dataValid` are all 0.
- R2: In the command stage, a frame whose low three payload bits are 0 (system reset) pulses `cmdValid` with `cmdCode` = 0. The parser stays in the command stage, so `shortFrame` stays 1.
- R3: In the command stage, payload code 1 (read while running) or code 2 (write while running) pulses `cmdValid` with that `cmdCode`. The parser then expects the count byte, so `shortFrame` goes to 0.
- R4: In the command stage, payload codes 3 to 7 pulse `cmdUnknown` and do not pulse `cmdValid`. The parser stays in the command stage.
- R5: The byte that follows a read or write command is taken as the transfer count N. It produces no output strobe.
- R6: The next three bytes are joined into a 24-bit address, first byte most significant. The third byte pulses `addrValid` with that address on `xferAddr`.
- R7: Every later byte pulses `dataValid`, with the payload on `dataByte` and the frame's start-bit direction on `dataDir`. `xferAddr` carries the address of the byte: the captured address for the first data byte, then one higher for each further byte, wrapping modulo 2^24.
- R8: With N of 1 or more, exactly N data bytes are reported. The parser then returns to the command stage and `shortFrame` is 1 again.
- R9: With N = 0, a single data byte is reported and the parser returns to the command stage.
- R10: `syncSeen` returns the parser to the command stage from any stage. A frame that arrives in the same cycle is dropped and produces no strobe.
- R11: Each strobe is a one-cycle pulse in the cycle after the accepted frame. At most one strobe is high at a time, and no strobe is raised without a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | One-cycle pulse: an acknowledged frame is on `frameData` |
| frameData | input | 8 | Frame payload; only the low 3 bits count in the command stage |
| frameDir | input | 1 | Start-bit direction of the frame (0 host, 1 target) |
| syncSeen | input | 1 | One-cycle pulse: the receiver saw a synchronisation frame |
| shortFrame | output | 1 | 1 while in the command stage (3-bit payload expected) |
| cmdValid | output | 1 | Known command pulse |
| cmdUnknown | output | 1 | Unknown command pulse |
| cmdCode | output | 3 | Last command code |
| addrValid | output | 1 | Address assembled pulse |
| xferAddr | output | 24 | Transfer address, or address of the current data byte |
| dataValid | output | 1 | Data byte pulse |
| dataByte | output | 8 | Data byte payload |
| dataDir | output | 1 | Direction of the data byte |

## Verification
The assertions assume that `frameValid` and `syncSeen` are single-cycle pulses. They also assume that `frameValid` only ever carries a frame the receiver has acknowledged, and that its length matches the one `shortFrame` asked for. The bench drives every frame and every sync as a pulse one cycle wide, placed between clock edges, and waits one cycle between events. It sends command codes only while the parser is in the command stage. The one deliberate overlap is a frame raised in the same cycle as a sync, which is how the sync priority is tested.

// File: rtl/dbg_parser_pkg.sv
package dbg_parser_pkg;

  localparam logic [2:0] CODE_SYS_RESET = 3'd0;
  localparam logic [2:0] CODE_READ      = 3'd1;
  localparam logic [2:0] CODE_WRITE     = 3'd2;

  typedef enum logic [1:0] {
    ST_CMD   = 2'd0,
    ST_COUNT = 2'd1,
    ST_ADDR  = 2'd2,
    ST_DATA  = 2'd3
  } parseState_t;

  typedef struct packed {
    logic cmdKnown;
    logic cmdUnknown;
    logic loadCount;
    logic shiftAddr;
    logic lastAddr;
    logic emitData;
  } ctrlStrb_t;

endpackage

// File: rtl/dbg_parser_ctrl.sv
module dbg_parser_ctrl
  import dbg_parser_pkg::*;
#(
  parameter int CMD_W      = 3,
  parameter int ADDR_BYTES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameValid,
  input  logic [CMD_W-1:0] frameCmd,
  input  logic             syncSeen,
  input  logic             lastData,
  output ctrlStrb_t        strb,
  output logic             cmdMode
);

  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  parseState_t state, stateNext;
  logic [IDX_W-1:0] addrIdx, addrIdxNext;
  logic accept;

  assign accept  = frameValid && !syncSeen;
  assign cmdMode = (state == ST_CMD);

  always_comb begin
    stateNext   = state;
    addrIdxNext = addrIdx;
    strb        = '0;
    if (syncSeen) begin
      stateNext   = ST_CMD;
      addrIdxNext = '0;
    end else if (accept) begin
      unique case (state)
        ST_CMD: begin
          if (frameCmd == CMD_W'(CODE_SYS_RESET)) begin
            strb.cmdKnown = 1'b1;
          end else if (frameCmd == CMD_W'(CODE_READ) || frameCmd == CMD_W'(CODE_WRITE)) begin
            strb.cmdKnown = 1'b1;
            stateNext     = ST_COUNT;
          end else begin
            strb.cmdUnknown = 1'b1;
          end
        end
        ST_COUNT: begin
          strb.loadCount = 1'b1;
          addrIdxNext    = '0;
          stateNext      = ST_ADDR;
        end
        ST_ADDR: begin
          strb.shiftAddr = 1'b1;
          if (addrIdx == LAST_IDX) begin
            strb.lastAddr = 1'b1;
            stateNext     = ST_DATA;
          end else begin
            addrIdxNext = addrIdx + 1'b1;
          end
        end
        ST_DATA: begin
          strb.emitData = 1'b1;
          if (lastData) stateNext = ST_CMD;
        end
        default: stateNext = ST_CMD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_CMD;
      addrIdx <= '0;
    end else begin
      state   <= stateNext;
      addrIdx <= addrIdxNext;
    end
  end

  a_r10_sync_to_cmd: assert property (@(posedge clk) disable iff (!rstN)
    syncSeen |=> cmdMode);

  a_r3_rw_leaves_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (cmdMode && frameValid && !syncSeen &&
     (frameCmd == CMD_W'(CODE_READ) || frameCmd == CMD_W'(CODE_WRITE))) |=> !cmdMode);

  a_r11_strobe_needs_frame: assert property (@(posedge clk) disable iff (!rstN)
    (|strb) |-> (frameValid && !syncSeen));

  a_r8_last_data_to_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emitData && lastData) |=> cmdMode);

endmodule

// File: rtl/dbg_parser_dpath.sv
module dbg_parser_dpath
  import dbg_parser_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CMD_W  = 3,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameDir,
  output logic              lastData,
  output logic              cmdValid,
  output logic              cmdUnknown,
  output logic [CMD_W-1:0]  cmdCode,
  output logic              addrValid,
  output logic [ADDR_W-1:0] xferAddr,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataByte,
  output logic              dataDir
);

  localparam int KEEP_W = ADDR_W - DATA_W;

  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] addrAcc;
  logic [ADDR_W-1:0] addrShifted;

  assign lastData    = (count <= CNT_W'(1));
  assign addrShifted = {addrAcc[KEEP_W-1:0], frameData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= '0;
      addrAcc    <= '0;
      xferAddr   <= '0;
      cmdCode    <= '0;
      cmdValid   <= 1'b0;
      cmdUnknown <= 1'b0;
      addrValid  <= 1'b0;
      dataValid  <= 1'b0;
      dataByte   <= '0;
      dataDir    <= 1'b0;
    end else begin
      cmdValid   <= strb.cmdKnown;
      cmdUnknown <= strb.cmdUnknown;
      addrValid  <= strb.lastAddr;
      dataValid  <= strb.emitData;
      if (strb.cmdKnown || strb.cmdUnknown) cmdCode <= frameData[CMD_W-1:0];
      if (strb.loadCount) count <= CNT_W'(frameData);
      if (strb.shiftAddr) addrAcc <= addrShifted;
      if (strb.lastAddr) xferAddr <= addrShifted;
      if (strb.emitData) begin
        dataByte <= frameData;
        dataDir  <= frameDir;
        xferAddr <= addrAcc;
        addrAcc  <= addrAcc + ADDR_W'(1);
        if (count != '0) count <= count - CNT_W'(1);
      end
    end
  end

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdValid, cmdUnknown, addrValid, dataValid}));

  a_r6_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (addrAcc == xferAddr));

  a_r7_addr_advance: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> (addrAcc == xferAddr + ADDR_W'(1)));

  a_r8_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emitData && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1)));

endmodule

// File: rtl/dbg_access_parser.sv
module dbg_access_parser
  import dbg_parser_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CMD_W  = 3,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameDir,
  input  logic              syncSeen,
  output logic              shortFrame,
  output logic              cmdValid,
  output logic              cmdUnknown,
  output logic [CMD_W-1:0]  cmdCode,
  output logic              addrValid,
  output logic [ADDR_W-1:0] xferAddr,
  output logic              dataValid,
  output logic [DATA_W-1:0] dataByte,
  output logic              dataDir
);

  localparam int ADDR_BYTES = ADDR_W / DATA_W;

  ctrlStrb_t strb;
  logic lastData;

  dbg_parser_ctrl #(
    .CMD_W(CMD_W),
    .ADDR_BYTES(ADDR_BYTES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .frameValid(frameValid),
    .frameCmd(frameData[CMD_W-1:0]),
    .syncSeen(syncSeen),
    .lastData(lastData),
    .strb(strb),
    .cmdMode(shortFrame)
  );

  dbg_parser_dpath #(
    .DATA_W(DATA_W),
    .CMD_W(CMD_W),
    .CNT_W(CNT_W),
    .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .frameData(frameData),
    .frameDir(frameDir),
    .lastData(lastData),
    .cmdValid(cmdValid),
    .cmdUnknown(cmdUnknown),
    .cmdCode(cmdCode),
    .addrValid(addrValid),
    .xferAddr(xferAddr),
    .dataValid(dataValid),
    .dataByte(dataByte),
    .dataDir(dataDir)
  );

endmodule

// File: tb/dbg_access_parser_tb.sv
module dbg_access_parser_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameValid = 1'b0;
  logic [7:0]  frameData = '0;
  logic        frameDir = 1'b0;
  logic        syncSeen = 1'b0;
  logic        shortFrame, cmdValid, cmdUnknown, addrValid, dataValid, dataDir;
  logic [2:0]  cmdCode;
  logic [23:0] xferAddr;
  logic [7:0]  dataByte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_access_parser u_dut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameData(frameData),
    .frameDir(frameDir), .syncSeen(syncSeen), .shortFrame(shortFrame),
    .cmdValid(cmdValid), .cmdUnknown(cmdUnknown), .cmdCode(cmdCode),
    .addrValid(addrValid), .xferAddr(xferAddr), .dataValid(dataValid),
    .dataByte(dataByte), .dataDir(dataDir)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {cmdValid, cmdUnknown, addrValid, dataValid};
  endfunction

  // drive one pulse between edges; outputs are visible on return
  task automatic pulse(input logic [7:0] d, input logic dir, input logic fr, input logic sy);
    @(negedge clk);
    frameValid = fr; frameData = d; frameDir = dir; syncSeen = sy;
    @(negedge clk);
    frameValid = 1'b0; syncSeen = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic dir);
    pulse(d, dir, 1'b1, 1'b0);
  endtask

  task automatic expectQuiet(input string req, input logic expShort);
    check(strobes() == 4'b0000, req, {28'd0, strobes()}, 32'd0);
    check(shortFrame == expShort, req, {31'd0, shortFrame}, {31'd0, expShort});
  endtask

  task automatic openXfer(input logic [2:0] code, input logic [7:0] n, input logic [23:0] a);
    sendFrame({5'd0, code}, 1'b0);
    check(cmdValid && cmdCode == code, "R3", {29'd0, cmdCode}, {29'd0, code});
    check(!shortFrame, "R3", {31'd0, shortFrame}, 32'd0);
    sendFrame(n, 1'b0);
    expectQuiet("R5", 1'b0);
    sendFrame(a[23:16], 1'b0);
    expectQuiet("R6", 1'b0);
    sendFrame(a[15:8], 1'b0);
    expectQuiet("R6", 1'b0);
    sendFrame(a[7:0], 1'b0);
    check(strobes() == 4'b0010, "R6", {28'd0, strobes()}, 32'h2);
    check(xferAddr == a, "R6", {8'd0, xferAddr}, {8'd0, a});
  endtask

  task automatic dataByteChk(input logic [7:0] d, input logic dir, input logic [23:0] expAddr,
                             input logic expShort, input string req);
    sendFrame(d, dir);
    check(strobes() == 4'b0001, "R7", {28'd0, strobes()}, 32'h1);
    check(dataByte == d && dataDir == dir, "R7", {23'd0, dataDir, dataByte}, {23'd0, dir, d});
    check(xferAddr == expAddr, "R7", {8'd0, xferAddr}, {8'd0, expAddr});
    check(shortFrame == expShort, req, {31'd0, shortFrame}, {31'd0, expShort});
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    expectQuiet("R1", 1'b1);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    expectQuiet("R11", 1'b1);
  endtask

  task automatic testSysReset();
    sendFrame(8'h00, 1'b0);
    check(cmdValid && !cmdUnknown && cmdCode == 3'd0, "R2", {28'd0, strobes()}, 32'h8);
    check(shortFrame, "R2", {31'd0, shortFrame}, 32'd1);
    @(negedge clk);
    expectQuiet("R11", 1'b1);
  endtask

  task automatic testUnknown();
    for (int c = 3; c < 8; c++) begin
      sendFrame(8'(c), 1'b0);
      check(strobes() == 4'b0100, "R4", {28'd0, strobes()}, 32'h4);
      check(shortFrame, "R4", {31'd0, shortFrame}, 32'd1);
    end
  endtask

  task automatic testRead();
    openXfer(3'd1, 8'd2, 24'h123456);
    dataByteChk(8'hAA, 1'b1, 24'h123456, 1'b0, "R7");
    dataByteChk(8'hBB, 1'b1, 24'h123457, 1'b1, "R8");
  endtask

  task automatic testWrite();
    openXfer(3'd2, 8'd3, 24'h00FF10);
    dataByteChk(8'h01, 1'b0, 24'h00FF10, 1'b0, "R7");
    dataByteChk(8'h02, 1'b0, 24'h00FF11, 1'b0, "R7");
    dataByteChk(8'h03, 1'b0, 24'h00FF12, 1'b1, "R8");
  endtask

  task automatic testWrap();
    openXfer(3'd1, 8'd2, 24'hFFFFFF);
    dataByteChk(8'h5A, 1'b1, 24'hFFFFFF, 1'b0, "R7");
    dataByteChk(8'hA5, 1'b1, 24'h000000, 1'b1, "R7");
  endtask

  task automatic testZeroCount();
    openXfer(3'd2, 8'd0, 24'h000100);
    dataByteChk(8'h77, 1'b0, 24'h000100, 1'b1, "R9");
    sendFrame(8'h00, 1'b0);
    check(cmdValid && cmdCode == 3'd0, "R9", {29'd0, cmdCode}, 32'd0);
  endtask

  task automatic testSyncMid();
    sendFrame(8'h01, 1'b0);
    sendFrame(8'h04, 1'b0);
    sendFrame(8'h12, 1'b0);
    pulse(8'h00, 1'b0, 1'b0, 1'b1);
    expectQuiet("R10", 1'b1);
    sendFrame(8'h00, 1'b0);
    check(cmdValid && cmdCode == 3'd0, "R10", {28'd0, strobes()}, 32'h8);
  endtask

  task automatic testSyncCollision();
    openXfer(3'd1, 8'd5, 24'h0A0B0C);
    pulse(8'h99, 1'b1, 1'b1, 1'b1);
    expectQuiet("R10", 1'b1);
  endtask

  initial begin
    testReset();
    testSysReset();
    testUnknown();
    testRead();
    testWrite();
    testWrap();
    testZeroCount();
    testSyncMid();
    testSyncCollision();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule